// File: doc/BRIEF.md
# Energy Sum Merger with Quad-Linear Encoder

This block forms the final missing-energy and total-energy results of a calorimeter trigger. Each cycle it takes up to three partial sums for each of three quantities: signed x and y projections and an unsigned scalar transverse energy. Each partial source has its own valid strobe. The block adds the valid partials of each quantity and limits each total to a 4 TeV full scale. It then compresses the total into an 8-bit quad-linear code and appends an odd parity bit.

Each of the two projections leaves as a sign bit plus an encoded magnitude. The scalar total leaves as the encoded magnitude alone. A per-quantity overflow flag marks totals that hit the saturation limit. The path is fully pipelined: it accepts a new set of partials every cycle and delivers each result a fixed three cycles later. One LSB is 1 GeV at the inputs.

Top module: `esum_merge`

## Requirements
- R1: Each total is the signed sum of the partials of that quantity whose source bit in `in_vld` is set; a partial whose source bit is clear adds zero. Source i occupies bits [i*W +: W] of its input bus.
- R2: A total whose magnitude exceeds 4095 is clamped to magnitude 4095 and encodes as code 0xFF. The lane's bit in `out_ovf` is then set (bit0 x, bit1 y, bit2 scalar); otherwise that bit is clear.
- R3: For the x and y words, bit 8 is the sign: 1 exactly when the total is negative, 0 for zero or positive totals. The code carries the magnitude.
- R4: Code bits [7:6] hold the range r and bits [5:0] the mantissa m, meaning m*4^r GeV. The encoder picks the smallest r with magnitude < 64*4^r and sets m = magnitude >> 2r, truncating toward zero.
- R5: Magnitudes from 4032 to 4095 encode as 0xFF with the overflow bit clear.
- R6: Parity is odd. Bit 9 of `out_ex`/`out_ey` makes bits [9:0] hold an odd number of ones. Bit 8 of `out_et` does the same for bits [8:0].
- R7: Inputs sampled at one rising edge appear on the outputs after the third rising edge, counting that edge. `out_valid` is then high exactly when any `in_vld` bit was set. A new input set is accepted every cycle.
- R8: While `rst_n` is low at a rising edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 3 | Valid strobe, one per partial source |
| in_ex | input | 42 | Three signed 14-bit partial x sums |
| in_ey | input | 42 | Three signed 14-bit partial y sums |
| in_et | input | 39 | Three unsigned 13-bit partial scalar sums |
| out_valid | output | 1 | Result valid |
| out_ex | output | 10 | {parity, sign, range[1:0], mantissa[5:0]} for x |
| out_ey | output | 10 | {parity, sign, range[1:0], mantissa[5:0]} for y |
| out_et | output | 9 | {parity, range[1:0], mantissa[5:0]} for scalar |
| out_ovf | output | 3 | Saturation flags {scalar, y, x} |

## Verification
Saturation and sign handling can fall in the same cycle: a strongly negative x total must clamp to full scale and still carry its sign bit. In that same cycle, the y total sits between 4032 and 4095, where the code is all ones but no overflow may be reported. The bench drives three large negative x partials together with a y set summing into that band. It compares each whole output word and the flags against a model computed from the requirements. A back-to-back stream with changing valid masks checks that neither function leaks across cycles.

// File: rtl/esum_pkg.sv
// Shared constants for the energy sum merger.
// Assumes three partial sources and three quantities (x, y, scalar).
package esum_pkg;
    localparam int NUM_SRC  = 3;
    localparam int NUM_LANE = 3;
    localparam int LANE_X   = 0;
    localparam int LANE_Y   = 1;
    localparam int LANE_T   = 2;
endpackage

// File: rtl/esum_add3.sv
// Adds the valid partial sums of one quantity and registers the total.
// Assumes partials are signed IN_W-bit words packed source 0 lowest and
// that SUM_W is wide enough for the sum of all sources.
module esum_add3 #(
    parameter int N     = 3,
    parameter int IN_W  = 14,
    parameter int SUM_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            vld,
    input  logic [N*IN_W-1:0]       part,
    output logic signed [SUM_W-1:0] sum_q
);
    logic signed [SUM_W-1:0] acc;

    // Sign-extend and accumulate only the partials whose strobe is set.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i]) begin
                acc = acc + SUM_W'($signed(part[i*IN_W +: IN_W]));
            end
        end
    end

    // Stage 1 register.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= acc;
    end
endmodule

// File: rtl/esum_satmag.sv
// Converts a signed total to sign and magnitude and clamps the magnitude
// to the full-scale value. Assumes SUM_W > MAG_W.
module esum_satmag #(
    parameter int SUM_W = 16,
    parameter int MAG_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SUM_W-1:0] sum,
    output logic                    sign_q,
    output logic [MAG_W-1:0]        mag_q,
    output logic                    ovf_q
);
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << MAG_W) - 1);

    logic             neg;
    logic [SUM_W-1:0] absval;
    logic             over;

    // Absolute value and saturation test.
    always_comb begin
        neg    = sum[SUM_W-1];
        absval = neg ? SUM_W'(-sum) : SUM_W'(sum);
        over   = absval > SAT_MAX;
    end

    // Stage 2 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            mag_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            sign_q <= neg;
            mag_q  <= over ? SAT_MAX[MAG_W-1:0] : absval[MAG_W-1:0];
            ovf_q  <= over;
        end
    end

    // R3: a zero magnitude never carries a negative sign.
    a_r3_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_q == '0) |-> !sign_q);
endmodule

// File: rtl/esum_qlin.sv
// Quad-linear encoder: range field plus mantissa, each range step a factor
// 2^STEP_SH coarser. Emits {odd parity, sign, code}. Assumes MAG_W equals
// MANT_W + STEP_SH*(2^RANGE_W - 1).
module esum_qlin #(
    parameter int MAG_W   = 12,
    parameter int RANGE_W = 2,
    parameter int MANT_W  = 6,
    parameter int STEP_SH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sign,
    input  logic [MAG_W-1:0]            mag,
    input  logic                        ovf,
    output logic [RANGE_W+MANT_W+1:0]   word_q,
    output logic                        ovf_q
);
    localparam int               CODE_W   = RANGE_W + MANT_W;
    localparam int               NUM_RNG  = 1 << RANGE_W;
    localparam logic [MAG_W-1:0] MANT_LIM = MAG_W'(1) << MANT_W;

    logic [RANGE_W-1:0] rng;
    logic               found;
    logic [MANT_W-1:0]  mant;
    logic [CODE_W-1:0]  code;

    // Choose the smallest range whose scaled magnitude fits the mantissa.
    always_comb begin
        rng   = RANGE_W'(NUM_RNG - 1);
        found = 1'b0;
        for (int r = 0; r < NUM_RNG; r++) begin
            if (!found && ((mag >> (STEP_SH * r)) < MANT_LIM)) begin
                rng   = RANGE_W'(r);
                found = 1'b1;
            end
        end
        mant = MANT_W'(mag >> (STEP_SH * int'(rng)));
        code = {rng, mant};
    end

    // Stage 3 register with odd parity over sign and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            word_q <= {~^{sign, code}, sign, code};
            ovf_q  <= ovf;
        end
    end

    // R4: a nonzero range implies the mantissa is normalised.
    a_r4_smallest_range: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q[CODE_W-1 -: RANGE_W] != '0) |-> (word_q[MANT_W-1 -: STEP_SH] != '0));
endmodule

// File: rtl/esum_merge.sv
// Energy sum merger top: three lanes (x, y, scalar), each adding three
// partials, saturating and quad-linear encoding, plus a valid pipeline.
// Assumes scalar partials are unsigned and one bit narrower than PART_W.
module esum_merge
    import esum_pkg::*;
#(
    parameter int PART_W  = 14,
    parameter int RANGE_W = 2,
    parameter int MANT_W  = 6,
    parameter int STEP_SH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           in_vld,
    input  logic [NUM_SRC*PART_W-1:0]    in_ex,
    input  logic [NUM_SRC*PART_W-1:0]    in_ey,
    input  logic [NUM_SRC*(PART_W-1)-1:0] in_et,
    output logic                         out_valid,
    output logic [RANGE_W+MANT_W+1:0]    out_ex,
    output logic [RANGE_W+MANT_W+1:0]    out_ey,
    output logic [RANGE_W+MANT_W:0]      out_et,
    output logic [NUM_LANE-1:0]          out_ovf
);
    localparam int ET_W   = PART_W - 1;
    localparam int SUM_W  = PART_W + $clog2(NUM_SRC);
    localparam int CODE_W = RANGE_W + MANT_W;
    localparam int MAG_W  = MANT_W + STEP_SH * ((1 << RANGE_W) - 1);
    localparam int LAT    = 3;

    logic [NUM_SRC*PART_W-1:0] et_ext;
    logic [NUM_SRC*PART_W-1:0] lane_in   [NUM_LANE];
    logic [CODE_W+1:0]         lane_word [NUM_LANE];
    logic [LAT-1:0]            vld_pipe;
    logic [1:0]                since_rst;

    // Zero-extend the unsigned scalar partials to the signed lane width.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_etx
        assign et_ext[s*PART_W +: PART_W] = {1'b0, in_et[s*ET_W +: ET_W]};
    end

    assign lane_in[LANE_X] = in_ex;
    assign lane_in[LANE_Y] = in_ey;
    assign lane_in[LANE_T] = et_ext;

    // One add / saturate / encode pipeline per quantity.
    for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
        logic signed [SUM_W-1:0] sum;
        logic                    sgn;
        logic [MAG_W-1:0]        mag;
        logic                    ovf;

        esum_add3 #(.N(NUM_SRC), .IN_W(PART_W), .SUM_W(SUM_W)) u_add (
            .clk(clk), .rst_n(rst_n), .vld(in_vld), .part(lane_in[l]), .sum_q(sum));

        esum_satmag #(.SUM_W(SUM_W), .MAG_W(MAG_W)) u_sat (
            .clk(clk), .rst_n(rst_n), .sum(sum),
            .sign_q(sgn), .mag_q(mag), .ovf_q(ovf));

        esum_qlin #(.MAG_W(MAG_W), .RANGE_W(RANGE_W), .MANT_W(MANT_W),
                    .STEP_SH(STEP_SH)) u_enc (
            .clk(clk), .rst_n(rst_n), .sign(sgn), .mag(mag), .ovf(ovf),
            .word_q(lane_word[l]), .ovf_q(out_ovf[l]));

        // R2: a saturated lane always shows the all-ones code.
        a_r2_ovf_full_code: assert property (@(posedge clk) disable iff (!rst_n)
            out_ovf[l] |-> (lane_word[l][CODE_W-1:0] == '1));
    end

    assign out_ex = lane_word[LANE_X];
    assign out_ey = lane_word[LANE_Y];
    assign out_et = {lane_word[LANE_T][CODE_W+1], lane_word[LANE_T][CODE_W-1:0]};

    // Valid follows the data through the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[LAT-2:0], |in_vld};
    end
    assign out_valid = vld_pipe[LAT-1];

    // Cycles since reset, saturating, for the latency check window.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7: valid emerges exactly three edges after the strobes.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(|in_vld, 3)));

    // R6: every valid output word has odd parity.
    a_r6_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (^out_ex && ^out_ey && ^out_et));

    // R3: the scalar lane never becomes negative.
    a_r3_scalar_positive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !lane_word[LANE_T][CODE_W]);
endmodule

// File: tb/esum_merge_bench.sv
`timescale 1ns/1ps
module esum_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_vld = '0;
    logic [41:0] in_ex = '0;
    logic [41:0] in_ey = '0;
    logic [38:0] in_et = '0;
    logic        out_valid;
    logic [9:0]  out_ex, out_ey;
    logic [8:0]  out_et;
    logic [2:0]  out_ovf;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    esum_merge u_esum_merge (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ex(in_ex), .in_ey(in_ey),
        .in_et(in_et), .out_valid(out_valid), .out_ex(out_ex), .out_ey(out_ey),
        .out_et(out_et), .out_ovf(out_ovf));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {ovf, parity, sign, code} from R2..R6.
    function automatic logic [10:0] model(int total);
        int mag, r, m;
        logic ovf, sgn, par;
        logic [7:0] code;
        sgn = total < 0;
        mag = sgn ? -total : total;
        ovf = mag > 4095;
        if (ovf) mag = 4095;
        r = 0;
        while (r < 3 && mag >= (64 << (2 * r))) r++;
        m = mag >> (2 * r);
        code = {r[1:0], m[5:0]};
        par = ~^{sgn, code};
        return {ovf, par, sgn, code};
    endfunction

    task automatic drive(int x[3], int y[3], int t[3], logic [2:0] v);
        in_vld = v;
        in_ex = {14'(x[2]), 14'(x[1]), 14'(x[0])};
        in_ey = {14'(y[2]), 14'(y[1]), 14'(y[0])};
        in_et = {13'(t[2]), 13'(t[1]), 13'(t[0])};
    endtask

    function automatic int total(int p[3], logic [2:0] v);
        int s = 0;
        for (int i = 0; i < 3; i++) if (v[i]) s += p[i];
        return s;
    endfunction

    task automatic compare(string req, int x[3], int y[3], int t[3], logic [2:0] v);
        logic [10:0] mx, my, mt;
        mx = model(total(x, v));
        my = model(total(y, v));
        mt = model(total(t, v));
        chk({req, " valid"}, 32'(out_valid), 32'(|v));
        chk({req, " ex"}, 32'(out_ex), 32'(mx[9:0]));
        chk({req, " ey"}, 32'(out_ey), 32'(my[9:0]));
        chk({req, " et"}, 32'(out_et), 32'({mt[9], mt[7:0]}));
        chk({req, " ovf"}, 32'(out_ovf), 32'({mt[10], my[10], mx[10]}));
    endtask

    task automatic run_one(string req, int x[3], int y[3], int t[3], logic [2:0] v);
        @(negedge clk);
        drive(x, y, t, v);
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(req, x, y, t, v);
        drive('{0, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 3'b000);
    endtask

    // R8: outputs clear under reset even with active inputs.
    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        drive('{500, 600, 700}, '{-9, -9, -9}, '{900, 900, 900}, 3'b111);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R8 reset valid", 32'(out_valid), 32'd0);
        chk("R8 reset words", {out_ex, out_ey, out_et, out_ovf}, 32'd0);
        drive('{0, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 3'b000);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // R1, R4, R6: ordinary sums in low ranges.
    task automatic t_basic();
        run_one("R1 R4 basic", '{10, 20, 30}, '{-5, -6, -7}, '{100, 200, 300}, 3'b111);
        chk("R4 code 60", 32'(out_ex[7:0]), 32'h3C);
        chk("R6 parity ex", 32'(^out_ex), 32'd1);
        chk("R6 parity et", 32'(^out_et), 32'd1);
    endtask

    // R1, R7: masked sources contribute nothing; no strobe gives no valid.
    task automatic t_mask();
        run_one("R1 mask101", '{1000, -2000, 5}, '{7, 3000, -2}, '{40, 8000, 9}, 3'b101);
        chk("R1 mask ex code", 32'(out_ex[7:0]), 32'({2'd2, 6'(1005 >> 4)}));
        run_one("R1 mask010", '{1000, -2000, 5}, '{7, 3000, -2}, '{40, 8000, 9}, 3'b010);
        run_one("R7 none", '{1, 2, 3}, '{4, 5, 6}, '{7, 8, 9}, 3'b000);
    endtask

    // R4, R5: range boundaries and the top band without overflow.
    task automatic t_bounds();
        run_one("R4 b63", '{63, 0, 0}, '{255, 0, 0}, '{1023, 0, 0}, 3'b001);
        chk("R4 63 code", 32'(out_ex[7:0]), 32'h3F);
        chk("R4 255 code", 32'(out_ey[7:0]), 32'h7F);
        run_one("R4 b64", '{64, 0, 0}, '{-256, 0, 0}, '{1024, 0, 0}, 3'b001);
        chk("R4 64 code", 32'(out_ex[7:0]), 32'h50);
        run_one("R5 top", '{4032, 0, 0}, '{-4095, 0, 0}, '{4095, 0, 0}, 3'b001);
        chk("R5 no ovf", 32'(out_ovf), 32'd0);
        chk("R5 et ff", 32'(out_et[7:0]), 32'hFF);
        run_one("R4 zero", '{5, -5, 0}, '{0, 0, 0}, '{0, 0, 0}, 3'b111);
    endtask

    // R2, R3: saturation and sign in the same cycle as the no-overflow band.
    task automatic t_sat_sign();
        run_one("R2 R3 negsat", '{-3000, -3000, -3000}, '{2000, 2000, 50}, '{8191, 8191, 8191}, 3'b111);
        chk("R3 sign kept", 32'(out_ex[8]), 32'd1);
        chk("R2 ovf bits", 32'(out_ovf), 32'b101);
        run_one("R2 possat", '{4000, 96, 0}, '{-4000, -96, 0}, '{4096, 0, 0}, 3'b011);
    endtask

    // R7: back-to-back stream, one result per cycle.
    task automatic t_stream();
        int sx[6][3] = '{'{1, 2, 3}, '{-100, 50, 7}, '{4000, 4000, 0}, '{0, 0, 0}, '{300, 300, 300}, '{-1, 0, 0}};
        int sy[6][3] = '{'{9, 9, 9}, '{70, 80, 90}, '{-1, -1, -1}, '{5, 5, 5}, '{-2000, -2000, 0}, '{63, 1, 0}};
        int st[6][3] = '{'{0, 0, 1}, '{255, 1, 0}, '{3000, 1000, 95}, '{8, 8, 8}, '{64, 64, 64}, '{0, 0, 4096}};
        logic [2:0] sv[6] = '{3'b111, 3'b011, 3'b111, 3'b000, 3'b110, 3'b101};
        for (int n = 0; n < 9; n++) begin
            @(negedge clk);
            if (n >= 3) compare("R7 stream", sx[n-3], sy[n-3], st[n-3], sv[n-3]);
            if (n < 6) drive(sx[n], sy[n], st[n], sv[n]);
            else       drive('{0, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 3'b000);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_bounds();
        t_sat_sign();
        t_stream();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule